// File: doc/BRIEF.md
# Evaluation-Stack Pointer with Boundary Trap

This block holds the pointer of a small hardware evaluation stack and flags
stack operations that would run past either end. In every cycle it may receive
up to two pop requests and up to three push requests, each coming from a
different field of the current microinstruction. It works out the pointer
value for the next cycle and, in the same cycle as the request, raises a trap
when the combination of requests is illegal for the current pointer value.

The pointer can also be written directly through a load strobe, which takes
precedence over every pop and push in that cycle. The stack storage itself,
the decoding of the microinstruction and whatever reacts to the trap live
outside this block.

Top module: `evstack_ptr`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `ptr` to 0 at that edge.
- R2: With `load` low, any pop request (`pop_x` or `pop_z`, one or both) and no push lowers `ptr` by exactly one at the next edge; any push request (one, two or three of `push_x`, `push_y`, `push_z`) and no pop raises it by exactly one.
- R3: With `load` low, a cycle carrying at least one pop and at least one push leaves `ptr` unchanged; a cycle with no request also leaves it unchanged.
- R4: With `load` low, `trap` is high in the same cycle when a pop is requested while `ptr` is 0, or a push is requested while `ptr` is at its maximum (2^PTR_W-1, 15 by default).
- R5: With `load` low, `trap` is high when `pop_z` and a push are requested together while `ptr` is at its maximum, and when `pop_x` and a push are requested together while `ptr` is 0.
- R6: With `load` low, `trap` is high when `pop_x` and `pop_z` are both requested while `ptr` is 0 or 1, whether or not a push is requested as well.
- R7: When `load` is high, `ptr` takes `load_val` at the next edge regardless of the pop and push inputs, and `trap` is low in that cycle.
- R8: `trap` is low in every cycle that matches none of the conditions of R4, R5 and R6; a trapping request still moves `ptr` by the rules of R2 and R3, wrapping modulo 2^PTR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pop_x | input | 1 | Pop request from the first source field |
| pop_z | input | 1 | Pop request from the second source field |
| push_x | input | 1 | Push request from the first source field |
| push_y | input | 1 | Push request from the second source field |
| push_z | input | 1 | Push request from the third source field |
| load | input | 1 | Direct pointer write strobe |
| load_val | input | PTR_W | Value written when `load` is high |
| ptr | output | PTR_W | Current stack pointer |
| trap | output | 1 | Illegal-operation flag, valid in the request cycle |

## Verification
The bench builds the block with its default width of four bits, so the whole pointer range of sixteen values is small enough for a random walk to hit both ends many times, and both trapping boundaries (0, 1 and 15) are reached in directed steps as well. Directed cycles drive every pop/push combination at those boundary values, then a long random sequence with occasional loads and one mid-run reset is compared against a behavioural model on every clock. Loads place the pointer straight onto a boundary so that wrap-around after a trapping request is seen in both directions.

// File: rtl/evstack_pkg.sv
package evstack_pkg;

   // One cycle worth of stack requests, gathered from the microword fields.
   typedef struct packed {
      logic pop_x;
      logic pop_z;
      logic push_x;
      logic push_y;
      logic push_z;
   } evstack_req_t;

   function automatic logic any_pop(input evstack_req_t r);
      return r.pop_x | r.pop_z;
   endfunction

   function automatic logic any_push(input evstack_req_t r);
      return r.push_x | r.push_y | r.push_z;
   endfunction

endpackage

// File: rtl/evstack_trap_chk.sv
module evstack_trap_chk
   import evstack_pkg::*;
#(
   parameter int PTR_W = 4
) (
   input  evstack_req_t     req,
   input  logic [PTR_W-1:0] cur,
   input  logic             load,
   output logic             trap
);

   localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};
   localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

   logic at_bottom, at_one, at_top;
   logic pop_any, push_any;
   logic t_single, t_mixed, t_double;

   always_comb begin
      at_bottom = (cur == '0);
      at_one    = (cur == ONE);
      at_top    = (cur == TOP);
      pop_any   = any_pop(req);
      push_any  = any_push(req);

      // plain underflow / overflow
      t_single = (pop_any & at_bottom) | (push_any & at_top);
      // one pop source mixed with a push at an end
      t_mixed  = (req.pop_x & push_any & at_bottom) |
                 (req.pop_z & push_any & at_top);
      // both pop sources at once need two entries
      t_double = req.pop_x & req.pop_z & (at_bottom | at_one);

      trap = ~load & (t_single | t_mixed | t_double);
   end

endmodule

// File: rtl/evstack_next.sv
module evstack_next
   import evstack_pkg::*;
#(
   parameter int PTR_W = 4
) (
   input  evstack_req_t     req,
   input  logic [PTR_W-1:0] cur,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   output logic [PTR_W-1:0] nxt
);

   localparam logic [PTR_W-1:0] STEP = {{(PTR_W-1){1'b0}}, 1'b1};

   logic pop_any, push_any;

   always_comb begin
      pop_any  = any_pop(req);
      push_any = any_push(req);
      if (load)
         nxt = load_val;
      else begin
         unique case ({pop_any, push_any})
            2'b10:   nxt = cur - STEP;
            2'b01:   nxt = cur + STEP;
            default: nxt = cur;
         endcase
      end
   end

endmodule

// File: rtl/evstack_ptr.sv
module evstack_ptr
   import evstack_pkg::*;
#(
   parameter int PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pop_x,
   input  logic             pop_z,
   input  logic             push_x,
   input  logic             push_y,
   input  logic             push_z,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   output logic [PTR_W-1:0] ptr,
   output logic             trap
);

   localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

   generate
      if (PTR_W < 2) begin : g_bad_width
         $error("evstack_ptr: PTR_W must be at least 2");
      end
   endgenerate

   evstack_req_t     req;
   logic [PTR_W-1:0] ptr_nxt;
   logic [PTR_W-1:0] ptr_q;

   assign req = '{pop_x: pop_x, pop_z: pop_z,
                  push_x: push_x, push_y: push_y, push_z: push_z};

   evstack_next #(.PTR_W(PTR_W)) i_next (
      .req      (req),
      .cur      (ptr_q),
      .load     (load),
      .load_val (load_val),
      .nxt      (ptr_nxt)
   );

   evstack_trap_chk #(.PTR_W(PTR_W)) i_trap (
      .req  (req),
      .cur  (ptr_q),
      .load (load),
      .trap (trap)
   );

   always_ff @(posedge clk) begin
      if (rst) ptr_q <= '0;
      else     ptr_q <= ptr_nxt;
   end

   assign ptr = ptr_q;

   logic pop_in, push_in;
   assign pop_in  = pop_x | pop_z;
   assign push_in = push_x | push_y | push_z;

   AST_RESET_ZERO: assert property (@(posedge clk)
      rst |=> ptr == '0);                                            // R1

   AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
      (!load && pop_in && !push_in) |=> ptr == $past(ptr) - 1'b1);   // R2

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
      (!load && push_in && !pop_in) |=> ptr == $past(ptr) + 1'b1);   // R2

   AST_MIX_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load && pop_in && push_in) |=> $stable(ptr));                // R3

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (!load && pop_in && ptr == '0) |-> trap);                      // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (!load && push_in && ptr == TOP) |-> trap);                    // R4

   AST_DOUBLE_POP: assert property (@(posedge clk) disable iff (rst)
      (!load && pop_x && pop_z && ptr <= 1) |-> trap);               // R6

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
      load |=> ptr == $past(load_val));                              // R7

   AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
      load |-> !trap);                                               // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!pop_in && !push_in) |-> !trap);                              // R8

endmodule

// File: tb/test_evstack_ptr.sv
module test_evstack_ptr;

   localparam int W   = 4;
   localparam int MAX = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pop_x = 0, pop_z = 0, push_x = 0, push_y = 0, push_z = 0;
   logic load = 0;
   logic [W-1:0] load_val = '0;
   logic [W-1:0] ptr;
   logic trap;

   int errors = 0;
   int checks = 0;
   int model  = 0;
   bit done   = 0;

   always #2 clk = ~clk;   // 250 MHz

   evstack_ptr #(.PTR_W(W)) i_evstack_ptr (
      .clk(clk), .rst(rst),
      .pop_x(pop_x), .pop_z(pop_z),
      .push_x(push_x), .push_y(push_y), .push_z(push_z),
      .load(load), .load_val(load_val),
      .ptr(ptr), .trap(trap)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_trap(input int p, input bit px, input bit pz,
                                   input bit ux, input bit uy, input bit uz,
                                   input bit ld);
      int pops, pushes;
      if (ld) return 0;
      pops   = px + pz;
      pushes = ux + uy + uz;
      if (pops > 0 && p == 0)       return 1;   // R4 underflow
      if (pushes > 0 && p == MAX)   return 1;   // R4 overflow
      if (pz && pushes > 0 && p == MAX) return 1; // R5
      if (px && pushes > 0 && p == 0)   return 1; // R5
      if (pops == 2 && p < 2)       return 1;   // R6
      return 0;                                  // R8
   endfunction

   function automatic string tag_for(input bit px, input bit pz,
                                     input bit ux, input bit uy, input bit uz,
                                     input bit ld);
      if (ld) return "R7";
      if ((px | pz) && (ux | uy | uz)) return "R3";
      if (px | pz | ux | uy | uz) return "R2";
      return "R8";
   endfunction

   // One cycle: drive after a falling edge, check trap before the rising
   // edge, step the model at the rising edge, check ptr after it.
   task automatic step(input bit px, input bit pz, input bit ux, input bit uy,
                       input bit uz, input bit ld, input int lv);
      int nm;
      pop_x = px; pop_z = pz; push_x = ux; push_y = uy; push_z = uz;
      load = ld; load_val = lv[W-1:0];
      #1;
      check(((px && pz) ? "R6 trap" : "R4/R5 trap"), trap,
            exp_trap(model, px, pz, ux, uy, uz, ld));
      if (ld) nm = lv;
      else begin
         nm = model;
         if (px | pz) nm = nm - 1;
         if (ux | uy | uz) nm = nm + 1;
         nm = nm & MAX;   // R8 wrap
      end
      @(posedge clk);
      model = nm;
      @(negedge clk);
      check({tag_for(px, pz, ux, uy, uz, ld), " ptr"}, ptr, model);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      pop_x = 1; push_y = 1; load = 0;
      @(posedge clk);
      model = 0;
      @(negedge clk);
      rst = 1'b0;
      check("R1 ptr after reset", ptr, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      @(negedge clk);
      do_reset();

      // R4: pop at empty, then climb to the top with mixed push sources
      step(1,0,0,0,0,0,0);               // pop at 0 -> trap, wraps to MAX
      step(0,0,0,0,0,1,0);               // load 0
      step(0,1,0,0,0,0,0);               // pop_z at 0
      step(0,0,0,0,0,1,0);
      for (int i = 0; i < MAX; i++)
         step(0,0,(i%3)==0,(i%3)==1,1,0,0);  // R2 multi push -> +1
      step(0,0,1,0,0,0,0);               // push at MAX -> trap
      step(0,0,0,0,0,1,MAX);
      // R5 at top
      step(0,1,1,0,0,0,0);               // pop_z + push at MAX
      step(1,0,0,1,0,0,0);               // pop_x + push at MAX
      // R2 double pop descends by one
      step(1,1,0,0,0,0,0);
      step(0,0,0,0,0,1,1);
      step(1,1,0,0,0,0,0);               // R6 at 1, no push
      step(0,0,0,0,0,1,1);
      step(1,1,0,0,1,0,0);               // R6 at 1, with push
      step(0,0,0,0,0,1,0);
      step(1,1,1,1,1,0,0);               // R6 at 0, with push
      step(1,0,1,0,0,0,0);               // R5 pop_x + push at 0
      step(0,1,0,1,0,0,0);               // pop_z + push at 0
      step(0,0,0,0,0,1,2);
      step(1,1,0,0,0,0,0);               // double pop at 2: legal
      // R7: load with every request asserted at a boundary
      step(1,1,1,1,1,1,0);
      step(1,1,1,1,1,1,MAX);
      step(0,0,0,0,0,0,0);               // R8 idle

      for (int n = 0; n < 3000; n++) begin
         bit ld;
         int r;
         if (n == 1500) do_reset();
         r  = $urandom;
         ld = ((r & 7) == 0);
         step(r[3], r[4], r[5], r[6], r[7], ld, r[15:12]);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule